// File: doc/BRIEF.md
# Multi-Channel DMA Register Bank

This block is the software-visible register file of a DMA copy engine with several independent channels. A simple request port carries a valid flag, a read/write flag, a byte address, a byte count (1, 2, 4 or 8) and write data. Every request gets exactly one response on the following cycle, with an error flag and read data.

The address space starts with a global window at offsets 0x00 to 0x7F. Channel `i` then owns the 0x80-byte window that starts at `0x80*(i+1)`. The global window reports the channel count and the transfer capability, and holds the interrupt master enable and an attention summary. Each channel window holds:
- a control halfword
- a command byte
- a status doubleword
- a 64-bit descriptor chain pointer
- a 64-bit completion pointer
- a 32-bit error register

The bank drives the register values and a one-cycle command strobe to each channel's sequencer. It takes back from each sequencer a status load, a busy flag, error set pulses and an interrupt-disable set pulse.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every channel's status reads 0x3 (transfer state "halted" in bits 2:0). The chain pointer, completion pointer, control and error registers read 0. The interrupt master enable is 0 and no response is pending.
- R2: Global offset 0x00 (1 byte) reads NUM_CH. Global offset 0x01 (1 byte) reads the bit index of the most significant set bit of MAX_XFER. Writes to either are accepted and have no effect.
- R3: A 1-byte write to global offset 0x02 loads the master enable from write-data bit 0. A 1-byte read returns the enable in bit 0 and then clears it.
- R4: Channel `i` is addressed at `0x80*(i+1)` plus the register offset. An access to a window whose channel index is NUM_CH or above gets an error response.
- R5: The chain pointer (offsets 0x10 low and 0x14 high) and the completion pointer (0x18 low and 0x1C high) accept an 8-byte write at the low offset, or a 4-byte write to either half. A 4-byte write leaves the other half unchanged, and reads follow the same widths.
- R6: The 4-byte error register at offset 0x20 is set by sequencer pulses. Each written 1 clears the matching bit. A set and a clear in the same cycle leave the bit set.
- R7: Writes to the 8-byte status at offset 0x08 are ignored. Sequencer loads replace the status. A read returns the status with the inverse of the channel's busy flag ORed into bit 0.
- R8: A 2-byte control write at offset 0x00 stores bits 15:1. Bit 0 (interrupt disable) is cleared when the written bit 0 is 1 and is otherwise kept. A sequencer pulse sets bit 0.
- R9: A 1-byte command write at offset 0x04 stores the byte and raises that channel's command strobe, alone, for exactly the next cycle.
- R10: A byte count other than 1, 2, 4 or 8, a count that does not match the register, or an unmapped offset gets an error response and changes no state. It also raises no strobe.
- R11: Each request is answered in the next cycle. The read data is 0 for writes and for error responses.
- R12: The 4-byte attention status at global offset 0x04 has bit `i` set while channel `i`'s error register is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the bank |
| req_bytes | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 64 | Read data, right-aligned |
| irq_master_en | output | 1 | Global interrupt master enable |
| ch_ctrl | output | NUM_CH*16 | Control register of each channel |
| ch_cmd | output | NUM_CH*8 | Command byte of each channel |
| ch_cmd_stb | output | NUM_CH | One-cycle command strobe per channel |
| ch_chain_addr | output | NUM_CH*64 | Descriptor chain pointer per channel |
| ch_cmpl_addr | output | NUM_CH*64 | Completion pointer per channel |
| seq_status_we | input | NUM_CH | Load the status from the sequencer |
| seq_status | input | NUM_CH*64 | Status value to load |
| seq_busy | input | NUM_CH | Channel busy flag |
| seq_err_set | input | NUM_CH*32 | Error bits to set |
| seq_intdis_set | input | NUM_CH | Set the control interrupt-disable bit |

## Verification
The decoder is tried with every legal width on the pointers (full, low half, high half), so that a half write that clobbers the other half is caught. It is also tried with illegal widths, mismatched widths, unmapped offsets and a window past the last channel, which separates rejection from silent acceptance. The side-effect registers are exercised in orders that expose wrong priority: a read-to-clear repeated, an error clear coinciding with a set, and control writes with the disable bit both set and clear. The sequencer return paths (busy, status load) are toggled so that the OR into bit 0 is told apart from the stored status.

// File: rtl/dmarb_pkg.sv
// Package: register identifiers, offsets and access-width rules shared by the
// decoder, the channel slices and the global slice.
package dmarb_pkg;

    typedef enum logic [3:0] {
        RG_NONE, RG_NCH, RG_CAP, RG_IRQ, RG_ATTN,
        RG_CTRL, RG_CMD, RG_STAT, RG_CHAIN_LO, RG_CHAIN_HI,
        RG_CMPL_LO, RG_CMPL_HI, RG_ERR
    } reg_id_e;

    // global window offsets
    localparam logic [6:0] OFF_G_NCH  = 7'h00;
    localparam logic [6:0] OFF_G_CAP  = 7'h01;
    localparam logic [6:0] OFF_G_IRQ  = 7'h02;
    localparam logic [6:0] OFF_G_ATTN = 7'h04;

    // channel window offsets
    localparam logic [6:0] OFF_C_CTRL     = 7'h00;
    localparam logic [6:0] OFF_C_CMD      = 7'h04;
    localparam logic [6:0] OFF_C_STAT     = 7'h08;
    localparam logic [6:0] OFF_C_CHAIN_LO = 7'h10;
    localparam logic [6:0] OFF_C_CHAIN_HI = 7'h14;
    localparam logic [6:0] OFF_C_CMPL_LO  = 7'h18;
    localparam logic [6:0] OFF_C_CMPL_HI  = 7'h1C;
    localparam logic [6:0] OFF_C_ERR      = 7'h20;

    localparam logic [63:0] STAT_RESET = 64'h3;

    // Legal byte count for each register.
    function automatic logic size_ok(reg_id_e r, logic [3:0] b);
        case (r)
            RG_NCH, RG_CAP, RG_IRQ, RG_CMD:          return b == 4'd1;
            RG_CTRL:                                 return b == 4'd2;
            RG_ATTN, RG_CHAIN_HI, RG_CMPL_HI, RG_ERR: return b == 4'd4;
            RG_STAT:                                 return b == 4'd8;
            RG_CHAIN_LO, RG_CMPL_LO:                 return (b == 4'd4) || (b == 4'd8);
            default:                                 return 1'b0;
        endcase
    endfunction

    // Index of the highest set bit of a value (0 for 0).
    function automatic int msb_index(longint unsigned v);
        int r;
        r = 0;
        for (int i = 0; i < 64; i++)
            if (v[i]) r = i;
        return r;
    endfunction

endpackage

// File: rtl/dmarb_decode.sv
// Address decoder: splits the byte address into window number and offset,
// names the addressed register and judges the access legal or not.
// Assumes: window 0 is global, window k>0 is channel k-1; purely combinational.
module dmarb_decode
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    localparam int WIN_W = ADDR_W - 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        bytes,
    output reg_id_e           rid,
    output logic              is_chan,
    output logic [WIN_W-1:0]  chan_idx,
    output logic              legal
);

    logic [WIN_W-1:0] win;
    logic [6:0]       off;
    logic             in_range;

    assign win      = addr[ADDR_W-1:7];
    assign off      = addr[6:0];
    assign is_chan  = (win != '0);
    assign chan_idx = win - WIN_W'(1);
    assign in_range = is_chan && (win <= WIN_W'(NUM_CH));

    // Purpose: map the in-window offset to a register identifier.
    always_comb begin
        rid = RG_NONE;
        if (!is_chan) begin
            case (off)
                OFF_G_NCH:  rid = RG_NCH;
                OFF_G_CAP:  rid = RG_CAP;
                OFF_G_IRQ:  rid = RG_IRQ;
                OFF_G_ATTN: rid = RG_ATTN;
                default:    rid = RG_NONE;
            endcase
        end else begin
            case (off)
                OFF_C_CTRL:     rid = RG_CTRL;
                OFF_C_CMD:      rid = RG_CMD;
                OFF_C_STAT:     rid = RG_STAT;
                OFF_C_CHAIN_LO: rid = RG_CHAIN_LO;
                OFF_C_CHAIN_HI: rid = RG_CHAIN_HI;
                OFF_C_CMPL_LO:  rid = RG_CMPL_LO;
                OFF_C_CMPL_HI:  rid = RG_CMPL_HI;
                OFF_C_ERR:      rid = RG_ERR;
                default:        rid = RG_NONE;
            endcase
        end
    end

    assign legal = (rid != RG_NONE) && size_ok(rid, bytes) && (!is_chan || in_range);

endmodule

// File: rtl/dmarb_ptr64.sv
// 64-bit pointer register writable whole or by 32-bit half.
// Assumes: at most one of the three write enables is high in a cycle.
module dmarb_ptr64 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_full,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [63:0] wdata,
    output logic [63:0] q
);

    // Purpose: merge a full or half write into the stored pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_full) begin
            q <= wdata;
        end else if (wr_lo) begin
            q[31:0] <= wdata[31:0];
        end else if (wr_hi) begin
            q[63:32] <= wdata[31:0];
        end
    end

endmodule

// File: rtl/dmarb_channel.sv
// One channel slice: control, command, status, two pointers and error register,
// plus the combinational read value of the register named by rid.
// Assumes: wr is high only for a legal write aimed at this channel.
module dmarb_channel
    import dmarb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  reg_id_e     rid,
    input  logic [3:0]  wbytes,
    input  logic [63:0] wdata,
    input  logic        seq_status_we,
    input  logic [63:0] seq_status,
    input  logic        seq_busy,
    input  logic [31:0] seq_err_set,
    input  logic        seq_intdis_set,
    output logic [15:0] ctrl_o,
    output logic [7:0]  cmd_o,
    output logic        cmd_stb_o,
    output logic [63:0] chain_o,
    output logic [63:0] cmpl_o,
    output logic [31:0] err_o,
    output logic [63:0] rdata_o
);

    logic [63:0] stat_q;
    logic        wr_ctrl, wr_cmd, wr_err;
    logic        full_w;

    assign wr_ctrl = wr && (rid == RG_CTRL);
    assign wr_cmd  = wr && (rid == RG_CMD);
    assign wr_err  = wr && (rid == RG_ERR);
    assign full_w  = (wbytes == 4'd8);

    // Purpose: control register with the keep-or-clear interrupt-disable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else if (wr_ctrl) begin
            ctrl_o[15:1] <= wdata[15:1];
            ctrl_o[0]    <= wdata[0] ? 1'b0 : (ctrl_o[0] | seq_intdis_set);
        end else begin
            ctrl_o[0] <= ctrl_o[0] | seq_intdis_set;
        end
    end

    // Purpose: command byte and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o     <= '0;
            cmd_stb_o <= 1'b0;
        end else begin
            cmd_stb_o <= wr_cmd;
            if (wr_cmd) cmd_o <= wdata[7:0];
        end
    end

    // Purpose: status, written only by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)             stat_q <= STAT_RESET;
        else if (seq_status_we) stat_q <= seq_status;
    end

    // Purpose: error bits, cleared by written ones, set by the sequencer (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= '0;
        else        err_o <= (err_o & ~(wr_err ? wdata[31:0] : 32'h0)) | seq_err_set;
    end

    dmarb_ptr64 u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_full (wr && (rid == RG_CHAIN_LO) && full_w),
        .wr_lo   (wr && (rid == RG_CHAIN_LO) && !full_w),
        .wr_hi   (wr && (rid == RG_CHAIN_HI)),
        .wdata   (wdata),
        .q       (chain_o)
    );

    dmarb_ptr64 u_cmpl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_full (wr && (rid == RG_CMPL_LO) && full_w),
        .wr_lo   (wr && (rid == RG_CMPL_LO) && !full_w),
        .wr_hi   (wr && (rid == RG_CMPL_HI)),
        .wdata   (wdata),
        .q       (cmpl_o)
    );

    // Purpose: read value of the addressed register, sized by the access.
    always_comb begin
        case (rid)
            RG_CTRL:     rdata_o = {48'h0, ctrl_o};
            RG_CMD:      rdata_o = {56'h0, cmd_o};
            RG_STAT:     rdata_o = stat_q | {63'h0, ~seq_busy};
            RG_CHAIN_LO: rdata_o = full_w ? chain_o : {32'h0, chain_o[31:0]};
            RG_CHAIN_HI: rdata_o = {32'h0, chain_o[63:32]};
            RG_CMPL_LO:  rdata_o = full_w ? cmpl_o : {32'h0, cmpl_o[31:0]};
            RG_CMPL_HI:  rdata_o = {32'h0, cmpl_o[63:32]};
            RG_ERR:      rdata_o = {32'h0, err_o};
            default:     rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/dmarb_global.sv
// Global slice: channel count, transfer capability, interrupt master enable
// (cleared by a read) and the attention summary.
// Assumes: wr_irq and rd_irq come only from legal 1-byte accesses.
module dmarb_global
    import dmarb_pkg::*;
#(
    parameter int          NUM_CH   = 4,
    parameter int unsigned MAX_XFER = 40000,
    localparam int         CAP_IDX  = msb_index(64'(MAX_XFER))
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_irq,
    input  logic        rd_irq,
    input  logic        wbit,
    input  logic [31:0] attn,
    input  reg_id_e     rid,
    output logic        irq_en,
    output logic [63:0] rdata_o
);

    // Purpose: master enable, loaded by a write and cleared after a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_en <= 1'b0;
        else if (wr_irq) irq_en <= wbit;
        else if (rd_irq) irq_en <= 1'b0;
    end

    // Purpose: read value of the addressed global register.
    always_comb begin
        case (rid)
            RG_NCH:  rdata_o = 64'(NUM_CH);
            RG_CAP:  rdata_o = 64'(CAP_IDX);
            RG_IRQ:  rdata_o = {63'h0, irq_en};
            RG_ATTN: rdata_o = {32'h0, attn};
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/dma_regbank.sv
// Top: register bank of a multi-channel DMA copy engine. It decodes one request
// per cycle, updates the addressed slice and returns a registered response.
// Assumes: NUM_CH between 1 and 64; ADDR_W wide enough for NUM_CH+1 windows.
module dma_regbank
    import dmarb_pkg::*;
#(
    parameter int          NUM_CH   = 4,
    parameter int          ADDR_W   = 16,
    parameter int unsigned MAX_XFER = 40000,
    localparam int         WIN_W    = ADDR_W - 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_bytes,
    input  logic [63:0]          req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [63:0]          rsp_rdata,
    output logic                 irq_master_en,
    output logic [NUM_CH*16-1:0] ch_ctrl,
    output logic [NUM_CH*8-1:0]  ch_cmd,
    output logic [NUM_CH-1:0]    ch_cmd_stb,
    output logic [NUM_CH*64-1:0] ch_chain_addr,
    output logic [NUM_CH*64-1:0] ch_cmpl_addr,
    input  logic [NUM_CH-1:0]    seq_status_we,
    input  logic [NUM_CH*64-1:0] seq_status,
    input  logic [NUM_CH-1:0]    seq_busy,
    input  logic [NUM_CH*32-1:0] seq_err_set,
    input  logic [NUM_CH-1:0]    seq_intdis_set
);

    reg_id_e          rid;
    logic             is_chan, legal, acc;
    logic [WIN_W-1:0] chan_idx;
    logic [NUM_CH-1:0] chan_sel;
    logic [63:0]      ch_rd [NUM_CH];
    logic [31:0]      ch_err [NUM_CH];
    logic [63:0]      g_rd, chan_rd;
    logic [31:0]      attn;

    dmarb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr     (req_addr),
        .bytes    (req_bytes),
        .rid      (rid),
        .is_chan  (is_chan),
        .chan_idx (chan_idx),
        .legal    (legal)
    );

    assign acc = req_valid && legal;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign chan_sel[i] = is_chan && (chan_idx == WIN_W'(i));

        dmarb_channel u_ch (
            .clk            (clk),
            .rst_n          (rst_n),
            .wr             (acc && req_write && chan_sel[i]),
            .rid            (rid),
            .wbytes         (req_bytes),
            .wdata          (req_wdata),
            .seq_status_we  (seq_status_we[i]),
            .seq_status     (seq_status[i*64 +: 64]),
            .seq_busy       (seq_busy[i]),
            .seq_err_set    (seq_err_set[i*32 +: 32]),
            .seq_intdis_set (seq_intdis_set[i]),
            .ctrl_o         (ch_ctrl[i*16 +: 16]),
            .cmd_o          (ch_cmd[i*8 +: 8]),
            .cmd_stb_o      (ch_cmd_stb[i]),
            .chain_o        (ch_chain_addr[i*64 +: 64]),
            .cmpl_o         (ch_cmpl_addr[i*64 +: 64]),
            .err_o          (ch_err[i]),
            .rdata_o        (ch_rd[i])
        );
    end

    for (genvar b = 0; b < 32; b++) begin : g_attn
        if (b < NUM_CH) begin : g_live
            assign attn[b] = |ch_err[b];
        end else begin : g_tied
            assign attn[b] = 1'b0;
        end
    end

    dmarb_global #(.NUM_CH(NUM_CH), .MAX_XFER(MAX_XFER)) u_glb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_irq  (acc && req_write && !is_chan && (rid == RG_IRQ)),
        .rd_irq  (acc && !req_write && !is_chan && (rid == RG_IRQ)),
        .wbit    (req_wdata[0]),
        .attn    (attn),
        .rid     (rid),
        .irq_en  (irq_master_en),
        .rdata_o (g_rd)
    );

    // Purpose: pick the read value of the selected channel.
    always_comb begin
        chan_rd = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (chan_sel[i]) chan_rd = ch_rd[i];
    end

    // Purpose: registered response, one per request, data only for legal reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_rdata <= (acc && !req_write) ? (is_chan ? chan_rd : g_rd) : 64'h0;
        end
    end

endmodule

// File: rtl/dmarb_checker.sv
// Checker: temporal properties of the register bank, bound to dma_regbank.
module dmarb_checker #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [3:0]           req_bytes,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic                 irq_master_en,
    input logic [NUM_CH-1:0]    ch_cmd_stb,
    input logic [NUM_CH*64-1:0] ch_chain_addr
);

    logic size_bad, win_bad, irq_read;

    assign size_bad = !(req_bytes == 4'd1 || req_bytes == 4'd2 ||
                        req_bytes == 4'd4 || req_bytes == 4'd8);
    assign win_bad  = req_addr[ADDR_W-1:7] > (ADDR_W-7)'(NUM_CH);
    assign irq_read = !req_write && (req_addr == ADDR_W'(2)) && (req_bytes == 4'd1);

    a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r10_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && size_bad) |=> rsp_err);
    a_r4_window_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win_bad) |=> rsp_err);
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_cmd_stb));
    a_r9_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_cmd_stb) |-> $past(req_valid && req_write));
    a_r10_error_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (ch_cmd_stb == '0));
    a_r3_read_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && irq_read) |=> !irq_master_en);
    a_r5_pointer_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(ch_chain_addr));

endmodule

bind dma_regbank dmarb_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_bytes     (req_bytes),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .irq_master_en (irq_master_en),
    .ch_cmd_stb    (ch_cmd_stb),
    .ch_chain_addr (ch_chain_addr)
);

// File: tb/tb_dma_regbank.sv
// Scoreboard bench: the access task queues the expected response, and a monitor
// compares each response as it appears.
module tb_dma_regbank;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_bytes = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, rsp_err, irq_master_en;
    logic [63:0] rsp_rdata;
    logic [NCH*16-1:0] ch_ctrl;
    logic [NCH*8-1:0]  ch_cmd;
    logic [NCH-1:0]    ch_cmd_stb;
    logic [NCH*64-1:0] ch_chain_addr, ch_cmpl_addr;
    logic [NCH-1:0]    seq_status_we = '0, seq_busy = '0, seq_intdis_set = '0;
    logic [NCH*64-1:0] seq_status = '0;
    logic [NCH*32-1:0] seq_err_set = '0;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [64:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    dma_regbank dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .irq_master_en(irq_master_en), .ch_ctrl(ch_ctrl), .ch_cmd(ch_cmd),
        .ch_cmd_stb(ch_cmd_stb), .ch_chain_addr(ch_chain_addr), .ch_cmpl_addr(ch_cmpl_addr),
        .seq_status_we(seq_status_we), .seq_status(seq_status), .seq_busy(seq_busy),
        .seq_err_set(seq_err_set), .seq_intdis_set(seq_intdis_set)
    );

    function automatic logic [15:0] cb(input int ch, input logic [6:0] off);
        return 16'(128 * (ch + 1)) + 16'(off);
    endfunction

    // Caller is at a negedge; drives one request, returns at the next negedge.
    task automatic access(input bit wr, input logic [15:0] a, input logic [3:0] b,
                          input logic [63:0] d, input bit xerr, input logic [63:0] xdata,
                          input string tag);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_bytes = b; req_wdata = d;
        exp_q.push_back({xerr, xdata});
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare every response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R11 unexpected response: actual err=%0b data=%h expected none",
                         rsp_err, rsp_rdata);
            end else begin
                logic [64:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_err !== e[64] || rsp_rdata !== e[63:0]) begin
                    n_err++;
                    $display("FAIL %s: actual err=%0b data=%h expected err=%0b data=%h",
                             t, rsp_err, rsp_rdata, e[64], e[63:0]);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 no response after reset", {63'h0, rsp_valid}, 64'h0);
        check("R1 chain pointers", ch_chain_addr[63:0] | ch_chain_addr[255:192], 64'h0);
        check("R1 control", ch_ctrl, 64'h0);
        check("R1 irq enable", {63'h0, irq_master_en}, 64'h0);
        access(0, cb(0, 7'h08), 4'd8, 0, 0, 64'h3, "R1 status halted");
        access(0, cb(0, 7'h18), 4'd8, 0, 0, 64'h0, "R1 completion zero");
        // R2 constants
        access(0, 16'h0000, 4'd1, 0, 0, 64'd4, "R2 channel count");
        access(0, 16'h0001, 4'd1, 0, 0, 64'd15, "R2 capability msb index");
        access(1, 16'h0000, 4'd1, 64'h9, 0, 64'h0, "R2 write count");
        access(0, 16'h0000, 4'd1, 0, 0, 64'd4, "R2 count unchanged");
        // R3 interrupt enable
        access(1, 16'h0002, 4'd1, 64'hFF, 0, 64'h0, "R3 set enable");
        check("R3 enable after write", {63'h0, irq_master_en}, 64'h1);
        access(0, 16'h0002, 4'd1, 0, 0, 64'h1, "R3 first read");
        check("R3 enable cleared by read", {63'h0, irq_master_en}, 64'h0);
        access(0, 16'h0002, 4'd1, 0, 0, 64'h0, "R3 second read");
        // R5 chain pointer of channel 1
        access(1, cb(1, 7'h10), 4'd8, 64'h1122334455667788, 0, 0, "R5 full write");
        access(0, cb(1, 7'h10), 4'd8, 0, 0, 64'h1122334455667788, "R5 full read");
        access(1, cb(1, 7'h14), 4'd4, 64'hAABBCCDD, 0, 0, "R5 high write");
        access(0, cb(1, 7'h10), 4'd8, 0, 0, 64'hAABBCCDD55667788, "R5 high kept low");
        access(1, cb(1, 7'h10), 4'd4, 64'hFFFF_FFFF_0102_0304, 0, 0, "R5 low write");
        check("R5 chain output", ch_chain_addr[127:64], 64'hAABBCCDD01020304);
        access(0, cb(1, 7'h10), 4'd4, 0, 0, 64'h01020304, "R5 low read");
        access(0, cb(1, 7'h14), 4'd4, 0, 0, 64'hAABBCCDD, "R5 high read");
        access(1, cb(2, 7'h18), 4'd8, 64'h0000_1111_2222_3333, 0, 0, "R5 completion full");
        access(1, cb(2, 7'h1C), 4'd4, 64'h77, 0, 0, "R5 completion high");
        check("R5 completion output", ch_cmpl_addr[191:128], 64'h0000_0077_2222_3333);
        // R6 / R12 error register and attention
        seq_err_set[31:0] = 32'hF0F0;
        @(negedge clk);
        seq_err_set = '0;
        access(0, cb(0, 7'h20), 4'd4, 0, 0, 64'hF0F0, "R6 sequencer set");
        access(0, 16'h0004, 4'd4, 0, 0, 64'h1, "R12 attention set");
        access(1, cb(0, 7'h20), 4'd4, 64'h00F0, 0, 0, "R6 clear some");
        access(0, cb(0, 7'h20), 4'd4, 0, 0, 64'hF000, "R6 after partial clear");
        access(1, cb(0, 7'h20), 4'd4, 64'hFFFFFFFF, 0, 0, "R6 clear all");
        access(0, 16'h0004, 4'd4, 0, 0, 64'h0, "R12 attention cleared");
        seq_err_set[31:0] = 32'h1;
        access(1, cb(0, 7'h20), 4'd4, 64'h1, 0, 0, "R6 set with clear");
        seq_err_set = '0;
        access(0, cb(0, 7'h20), 4'd4, 0, 0, 64'h1, "R6 set wins");
        // R7 status
        access(1, cb(0, 7'h08), 4'd8, 64'hFFFF, 0, 0, "R7 status write");
        access(0, cb(0, 7'h08), 4'd8, 0, 0, 64'h3, "R7 write ignored");
        seq_status[63:0] = 64'h40; seq_status_we[0] = 1'b1;
        @(negedge clk);
        seq_status_we = '0;
        seq_busy[0] = 1'b1;
        access(0, cb(0, 7'h08), 4'd8, 0, 0, 64'h40, "R7 busy status");
        seq_busy[0] = 1'b0;
        access(0, cb(0, 7'h08), 4'd8, 0, 0, 64'h41, "R7 idle status");
        // R8 control of channel 3
        access(1, cb(3, 7'h00), 4'd2, 64'h1235, 0, 0, "R8 write with bit0");
        access(0, cb(3, 7'h00), 4'd2, 0, 0, 64'h1234, "R8 bit0 cleared");
        seq_intdis_set[3] = 1'b1;
        @(negedge clk);
        seq_intdis_set = '0;
        access(0, cb(3, 7'h00), 4'd2, 0, 0, 64'h1235, "R8 sequencer set");
        access(1, cb(3, 7'h00), 4'd2, 64'h00A0, 0, 0, "R8 write bit0 low");
        access(0, cb(3, 7'h00), 4'd2, 0, 0, 64'h00A1, "R8 bit0 kept");
        access(1, cb(3, 7'h00), 4'd2, 64'h00A1, 0, 0, "R8 write bit0 high");
        access(0, cb(3, 7'h00), 4'd2, 0, 0, 64'h00A0, "R8 bit0 cleared again");
        // R9 command strobe
        access(1, cb(2, 7'h04), 4'd1, 64'h5A, 0, 0, "R9 command write");
        check("R9 strobe channel 2 only", {60'h0, ch_cmd_stb}, 64'h4);
        check("R9 command byte out", {56'h0, ch_cmd[23:16]}, 64'h5A);
        @(negedge clk);
        check("R9 strobe one cycle", {60'h0, ch_cmd_stb}, 64'h0);
        access(0, cb(2, 7'h04), 4'd1, 0, 0, 64'h5A, "R9 command readback");
        // R10 illegal accesses
        access(1, cb(1, 7'h10), 4'd2, 64'hDEAD, 1, 0, "R10 pointer wrong width");
        access(0, cb(1, 7'h10), 4'd8, 0, 0, 64'hAABBCCDD01020304, "R10 pointer unchanged");
        access(1, cb(2, 7'h04), 4'd2, 64'hFF, 1, 0, "R10 command wrong width");
        check("R10 no strobe on error", {60'h0, ch_cmd_stb}, 64'h0);
        access(0, cb(2, 7'h04), 4'd1, 0, 0, 64'h5A, "R10 command unchanged");
        access(0, cb(0, 7'h08), 4'd3, 0, 1, 0, "R10 odd size");
        access(0, cb(0, 7'h40), 4'd4, 0, 1, 0, "R10 unmapped offset");
        access(1, 16'h0002, 4'd2, 64'h1, 1, 0, "R10 irq wrong width");
        check("R10 irq untouched", {63'h0, irq_master_en}, 64'h0);
        // R4 window mapping
        access(0, cb(4, 7'h04), 4'd1, 0, 1, 0, "R4 window past last channel");
        access(1, cb(3, 7'h04), 4'd1, 64'h33, 0, 0, "R4 last channel command");
        check("R4 strobe channel 3", {60'h0, ch_cmd_stb}, 64'h8);
        access(0, cb(1, 7'h04), 4'd1, 0, 0, 64'h0, "R4 other channel untouched");
        // R11 response on writes carries zero data (covered above); drain
        repeat (3) @(negedge clk);
        check("R11 all responses seen", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule